// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Latch Controller

This block sits in one channel of a synchronous buck controller and turns a current-limit detection into a cycle-counted protection sequence. Every rising edge of `clk` starts one switching cycle. At that edge the block samples `ilim_hit`, the result of the current-sense comparator. If the limit is seen while the block is armed, the high-side pulse of the cycle that starts is suppressed, along with the pulses of the eight cycles after it. The next eight cycles switch normally while the block watches for a second detection. If the limit is seen again in that window, the channel is latched off and power-good is pulled low. If it is not seen again, the block re-arms by itself.

The sequence has four named states:
- **ARMED** is idle.
- **SKIP** covers cycles 0 to 8 after a trigger, with the high side inhibited.
- **WATCH** covers cycles 9 to 16, with normal pulses.
- **TRIPPED** is the latched fault.

The transitions are:
- ARMED→SKIP: `ilim_hit` is sampled high.
- SKIP→SKIP: the skip count is still running.
- SKIP→WATCH: the edge that starts cycle 9 sees no detection.
- SKIP→TRIPPED: the edge that starts cycle 9 sees a detection.
- WATCH→TRIPPED: a detection is seen at the edge that starts any cycle from 10 to 16.
- WATCH→ARMED: the edge that starts cycle 17 sees no detection.
- WATCH→SKIP: the edge that starts cycle 17 sees a detection, which counts as a fresh trigger.
- Any state→ARMED: `enable` is low or `uvlo` is high at an edge.

Top module: `occ_guard`

## Requirements
- R1: After `rst_n` is released, and whenever the block is armed, `hs_inhibit`, `oc_latched` and `pgood_kill` are all low.
- R2: When the block is armed and `ilim_hit` is high at a rising edge, `hs_inhibit` goes high from that edge. That edge starts cycle 0.
- R3: `hs_inhibit` stays high for cycles 1 to 8 after the trigger, nine cycles in all. This holds whatever `ilim_hit` does at those edges.
- R4: In cycles 9 to 16 after a trigger, `hs_inhibit` is low unless the latch has been set.
- R5: If `ilim_hit` is high at the edge that starts any cycle from 9 to 16, `oc_latched` and `hs_inhibit` go high from that edge. Both boundary cycles, 9 and 16, trigger the latch.
- R6: If no detection occurs at the edges that start cycles 9 to 16, the edge that starts cycle 17 re-arms the block. A detection sampled at that same edge acts as a new trigger.
- R7: Once latched, `oc_latched`, `pgood_kill` and `hs_inhibit` stay high whatever `ilim_hit` does, until the block is cleared.
- R8: `enable` low at a rising edge clears the latch and the sequence, so all three outputs are low after that edge. `ilim_hit` has no effect while `enable` is low.
- R9: `uvlo` high at a rising edge clears the block in the same way as R8.
- R10: `ilim_hit` is sampled only at rising edges. A pulse that rises and falls between two edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock; each rising edge starts a cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel enable; low clears the block |
| uvlo | input | 1 | Supply lockout, active high; clears the block |
| ilim_hit | input | 1 | Current-limit detected, from the sense comparator |
| hs_inhibit | output | 1 | Suppress the high-side pulse of the current cycle |
| oc_latched | output | 1 | Over-current latch is set |
| pgood_kill | output | 1 | Forces power-good low |

## Verification
The assertions assume that `ilim_hit`, `enable` and `uvlo` are synchronous to `clk` and settled at every rising edge. They also rely on the length of an inhibited run being observable only while the block is not latched. The bench drives every input on the falling edge. The one exception is the deliberate mid-cycle pulse, which rises and falls well clear of both edges. Long random stretches drop `enable` now and then so that latched episodes end and new sequences start. A behavioural cycle-index model predicts all three outputs and is compared on every falling edge.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_SKIP    = 2'd1,
        ST_WATCH   = 2'd2,
        ST_TRIPPED = 2'd3
    } occ_state_e;

endpackage

// File: rtl/occ_cycle_ctr.sv
module occ_cycle_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Index of the cycle now running, counted from the trigger cycle (0).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i || start_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/occ_fsm.sv
module occ_fsm
    import occ_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             uvlo,
    input  logic             ilim_hit,
    input  logic [CNT_W-1:0] cnt_i,
    output occ_state_e       state_o,
    output logic             clr_o,
    output logic             start_o,
    output logic             inc_o
);

    // Index of the final inhibited cycle, and of the final watched cycle.
    localparam logic [CNT_W-1:0] SKIP_LAST  = CNT_W'(SKIP_CYCLES);
    localparam logic [CNT_W-1:0] WATCH_LAST = CNT_W'(SKIP_CYCLES + WATCH_CYCLES);

    occ_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        clr_o   = 1'b0;
        start_o = 1'b0;
        inc_o   = 1'b0;
        if (!enable || uvlo) begin
            state_d = ST_ARMED;
            clr_o   = 1'b1;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (ilim_hit) begin
                        state_d = ST_SKIP;
                        start_o = 1'b1;
                    end
                end
                ST_SKIP: begin
                    inc_o = 1'b1;
                    if (cnt_i == SKIP_LAST) begin
                        // This edge starts the first watched cycle.
                        state_d = ilim_hit ? ST_TRIPPED : ST_WATCH;
                    end
                end
                ST_WATCH: begin
                    if (cnt_i == WATCH_LAST) begin
                        // The window has closed: re-arm, and treat a hit as a new trigger.
                        if (ilim_hit) begin
                            state_d = ST_SKIP;
                            start_o = 1'b1;
                        end else begin
                            state_d = ST_ARMED;
                            clr_o   = 1'b1;
                        end
                    end else if (ilim_hit) begin
                        state_d = ST_TRIPPED;
                    end else begin
                        inc_o = 1'b1;
                    end
                end
                ST_TRIPPED: begin
                    state_d = ST_TRIPPED;
                end
                default: begin
                    state_d = ST_ARMED;
                    clr_o   = 1'b1;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/occ_out_dec.sv
module occ_out_dec
    import occ_pkg::*;
(
    input  occ_state_e state_i,
    output logic       hs_inhibit,
    output logic       oc_latched,
    output logic       pgood_kill
);

    always_comb begin
        hs_inhibit = 1'b0;
        oc_latched = 1'b0;
        pgood_kill = 1'b0;
        unique case (state_i)
            ST_ARMED: ;
            ST_SKIP: hs_inhibit = 1'b1;
            ST_WATCH: ;
            ST_TRIPPED: begin
                hs_inhibit = 1'b1;
                oc_latched = 1'b1;
                pgood_kill = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/occ_guard.sv
module occ_guard
    import occ_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic uvlo,
    input  logic ilim_hit,
    output logic hs_inhibit,
    output logic oc_latched,
    output logic pgood_kill
);

    localparam int CNT_W = $clog2(SKIP_CYCLES + WATCH_CYCLES + 1);

    occ_state_e       state;
    logic [CNT_W-1:0] cyc_idx;
    logic             ctr_clr;
    logic             ctr_start;
    logic             ctr_inc;

    occ_fsm #(
        .SKIP_CYCLES (SKIP_CYCLES),
        .WATCH_CYCLES(WATCH_CYCLES),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .uvlo    (uvlo),
        .ilim_hit(ilim_hit),
        .cnt_i   (cyc_idx),
        .state_o (state),
        .clr_o   (ctr_clr),
        .start_o (ctr_start),
        .inc_o   (ctr_inc)
    );

    occ_cycle_ctr #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctr_clr),
        .start_i(ctr_start),
        .inc_i  (ctr_inc),
        .cnt_o  (cyc_idx)
    );

    occ_out_dec u_dec (
        .state_i   (state),
        .hs_inhibit(hs_inhibit),
        .oc_latched(oc_latched),
        .pgood_kill(pgood_kill)
    );

endmodule

// File: rtl/occ_guard_chk.sv
module occ_guard_chk #(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic uvlo,
    input logic ilim_hit,
    input logic hs_inhibit,
    input logic oc_latched,
    input logic pgood_kill
);

    localparam int RUN_MAX = SKIP_CYCLES + 1;

    // Length of the current run of inhibited, unlatched cycles, including the one now running.
    logic [7:0] run_q;
    logic [7:0] run_now;
    logic       live;

    assign live    = enable && !uvlo;
    assign run_now = (hs_inhibit && !oc_latched) ? ((run_q == 8'hFF) ? run_q : run_q + 8'd1) : 8'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 8'd0;
        end else begin
            run_q <= run_now;
        end
    end

    a_r2_trigger_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (live && ilim_hit && !hs_inhibit) |=> hs_inhibit);

    a_r3_skip_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_now) <= RUN_MAX);

    a_r4_watch_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(run_now) == RUN_MAX && live && !ilim_hit) |=> !hs_inhibit);

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_latched && live) |=> (oc_latched && pgood_kill && hs_inhibit));

    a_r7_latch_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_latched) |-> (hs_inhibit && pgood_kill));

    a_r8_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!oc_latched && !hs_inhibit && !pgood_kill));

    a_r9_lockout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!oc_latched && !hs_inhibit && !pgood_kill));

endmodule

bind occ_guard occ_guard_chk #(
    .SKIP_CYCLES (SKIP_CYCLES),
    .WATCH_CYCLES(WATCH_CYCLES)
) u_occ_guard_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .uvlo      (uvlo),
    .ilim_hit  (ilim_hit),
    .hs_inhibit(hs_inhibit),
    .oc_latched(oc_latched),
    .pgood_kill(pgood_kill)
);

// File: tb/test_occ_guard.sv
`timescale 1ns/1ps
module test_occ_guard;

    localparam int CLK_P    = 10;
    localparam int SKIPN    = 8;
    localparam int WATCHN   = 8;
    localparam int WD_LIMIT = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic uvlo = 1'b0;
    logic ilim_hit = 1'b0;
    logic hs_inhibit, oc_latched, pgood_kill;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural reference: index of the running cycle since the trigger (-1 when armed) and a latch bit.
    int m_idx = -1;
    bit m_lat = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    occ_guard i_occ_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .uvlo      (uvlo),
        .ilim_hit  (ilim_hit),
        .hs_inhibit(hs_inhibit),
        .oc_latched(oc_latched),
        .pgood_kill(pgood_kill)
    );

    always @(posedge clk) begin
        if (!rst_n || !enable || uvlo) begin
            m_idx = -1;
            m_lat = 1'b0;
        end else if (m_lat) begin
            m_lat = 1'b1;
        end else if (m_idx < 0) begin
            if (ilim_hit) m_idx = 0;
        end else begin
            int n;
            n = m_idx + 1;
            if (n <= SKIPN) begin
                m_idx = n;
            end else if (n <= SKIPN + WATCHN) begin
                if (ilim_hit) m_lat = 1'b1;
                m_idx = n;
            end else begin
                m_idx = ilim_hit ? 0 : -1;
            end
        end
    end

    function automatic bit exp_inh();
        return m_lat || (m_idx >= 0 && m_idx <= SKIPN);
    endfunction

    // Every-cycle comparison against the model (all requirements, R2/R3/R4/R5/R7 in particular).
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (hs_inhibit !== exp_inh() || oc_latched !== m_lat || pgood_kill !== m_lat) begin
                errors++;
                $display("FAIL model R2/R3/R4/R5/R7 t=%0t: got inh=%b lat=%b pg=%b expected inh=%b lat=%b pg=%b",
                         $time, hs_inhibit, oc_latched, pgood_kill, exp_inh(), m_lat, m_lat);
            end
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0t: actual %b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic tick(input logic hit);
        ilim_hit = hit;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        chk("R1 reset inhibit", hs_inhibit, 1'b0);
        chk("R1 reset latch", oc_latched, 1'b0);
        chk("R1 reset pgood", pgood_kill, 1'b0);

        // First trigger; hits during the skip window are ignored.
        tick(1'b1);
        chk("R2 trigger inhibit", hs_inhibit, 1'b1);
        for (int i = 1; i <= 8; i++) begin
            tick(1'b1);
            chk("R3 skip cycle inhibit", hs_inhibit, 1'b1);
            chk("R3 skip no latch", oc_latched, 1'b0);
        end
        for (int i = 9; i <= 16; i++) begin
            tick(1'b0);
            chk("R4 watch pulses allowed", hs_inhibit, 1'b0);
        end
        tick(1'b0);
        chk("R6 re-armed no inhibit", hs_inhibit, 1'b0);
        chk("R1 armed no latch", oc_latched, 1'b0);

        // Repeat detection at cycle 16 latches.
        tick(1'b1);
        for (int i = 1; i <= 15; i++) tick(1'b0);
        chk("R4 cycle 15 free", hs_inhibit, 1'b0);
        tick(1'b1);
        chk("R5 latch at cycle 16", oc_latched, 1'b1);
        chk("R5 inhibit at cycle 16", hs_inhibit, 1'b1);
        chk("R7 pgood low", pgood_kill, 1'b1);
        for (int i = 0; i < 6; i++) tick(i[0]);
        chk("R7 latch held", oc_latched, 1'b1);
        chk("R7 inhibit held", hs_inhibit, 1'b1);
        enable = 1'b0;
        tick(1'b1);
        chk("R8 enable clears latch", oc_latched, 1'b0);
        chk("R8 enable clears inhibit", hs_inhibit, 1'b0);
        tick(1'b1);
        chk("R8 hit ignored while disabled", hs_inhibit, 1'b0);
        enable = 1'b1;
        tick(1'b0);

        // Repeat detection at cycle 9 latches; lockout clears.
        tick(1'b1);
        for (int i = 1; i <= 8; i++) tick(1'b0);
        tick(1'b1);
        chk("R5 latch at cycle 9", oc_latched, 1'b1);
        uvlo = 1'b1;
        tick(1'b0);
        chk("R9 lockout clears latch", oc_latched, 1'b0);
        chk("R9 lockout clears pgood", pgood_kill, 1'b0);
        uvlo = 1'b0;
        tick(1'b0);

        // A hit at cycle 17 is a fresh trigger, not a latch.
        tick(1'b1);
        for (int i = 1; i <= 16; i++) tick(1'b0);
        tick(1'b1);
        chk("R6 cycle 17 retrigger inhibit", hs_inhibit, 1'b1);
        chk("R6 cycle 17 no latch", oc_latched, 1'b0);
        enable = 1'b0;
        tick(1'b0);
        chk("R8 enable clears skip", hs_inhibit, 1'b0);
        enable = 1'b1;
        tick(1'b0);

        // Mid-cycle pulse between edges.
        ilim_hit = 1'b0;
        @(posedge clk);
        #(CLK_P/4) ilim_hit = 1'b1;
        #(CLK_P/2) ilim_hit = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 mid-cycle pulse ignored", hs_inhibit, 1'b0);

        // Random traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            ilim_hit = (($urandom % 100) < 15);
            enable   = (($urandom % 150) != 0);
            uvlo     = (($urandom % 400) == 0);
            @(posedge clk);
            @(negedge clk);
        end
        finish_run();
    end

endmodule